// File: doc/BRIEF.md
# Addressed Serial Configuration Loader

This block is a receive-only, three-wire serial port through which a host controller programs a small bank of 16-bit control words. The host presents a bit on the data pin and marks it with a falling edge of the serial clock. After 19 such bits it raises the enable pin. If the frame is well formed, that rising edge writes the 16 data bits into the register named by the 3-bit address that closes the frame.

The bank holds seven words. The four lowest addresses carry divider ratios and are double-buffered. A write there lands in a staging copy. Every enable rising edge moves the staging copies into the working outputs, so the host issues one extra, clockless enable edge to make a new ratio take effect. The three upper words are plain control words and change on the same edge that commits them.

All three pins are asynchronous to the system clock and are sampled through two-flop synchronizers. The pins are free-running levels with no valid/ready handshake, so the port cannot apply back-pressure. The host must space its edges so that each level lasts at least three system-clock cycles. After each enable rising edge, a programmable guard window rejects serial-clock edges and flags them.

Top module: `serial_cfg_port`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all seven working words, all four staging copies and `hold_err_o`.
- R2: Each falling edge of `sclk_i` captures `sdata_i`. A frame is 19 bits long. The first 16 bits are the data, most significant bit first. The last 3 bits are the address, most significant bit first, so the final bit is address bit 0. Word k appears on `cfg_o[16k+15:16k]`.
- R3: A frame to address 4, 5 or 6 changes its output word on the third rising `clk` edge after `sen_i` rises: two synchronizer flops, then one register stage.
- R4: A frame to address 0 to 3 writes only the staging copy. The output word keeps its old value through the committing edge.
- R5: Every enable rising edge copies each staging copy to its output word, taking the staging value from before that edge's own write. `cfg_o` changes at no other time. An extra edge with no bits shifted changes nothing except this copy.
- R6: An enable rising edge after a bit count other than 19 (for example 18 or 20) writes no register. The bit count clears on every enable rising edge, so the next 19-bit frame is accepted.
- R7: A well-formed frame carrying address 7 writes no register.
- R8: For `hold_cycles_i` clock cycles after an enable rising edge is registered, a falling `sclk_i` edge is neither shifted nor counted, and it sets `hold_err_o`.
- R9: Once set, `hold_err_o` stays 1 through later frames and enable edges until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sdata_i | input | 1 | Serial data pin, asynchronous |
| sclk_i | input | 1 | Serial clock pin; a bit is taken on its falling edge |
| sen_i | input | 1 | Enable pin; its rising edge commits a frame and promotes staged words |
| hold_cycles_i | input | 8 | Length of the guard window after an enable edge, in clock cycles |
| cfg_o | output | 112 | Seven working words; word k at bits 16k+15 to 16k |
| hold_err_o | output | 1 | Sticky flag for a serial-clock edge seen inside the guard window |

## Verification
Each pin change takes two clocks through the synchronizer, and the resulting edge acts on the third rising clock edge. A committed word is therefore due three clocks after the enable pin rises. The bench drives pins on falling clock edges and samples there as well. It checks once after two rising edges (old value expected) and once after the third (new value expected). Every other check waits six clocks after the stimulus, and every frame opens with a 16-cycle quiet gap, longer than the 8-cycle guard window, so guard edges land only where a test places them. The stray clock edge in the guard test is placed two clocks after the enable edge, well inside the window.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int PIN_DATA = 0;
  localparam int PIN_SCLK = 1;
  localparam int PIN_EN   = 2;
  localparam int NUM_PINS = 3;
endpackage

// File: rtl/scp_pin_sync.sv
module scp_pin_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= pin_i[g];
        stab_q <= meta_q;
      end
    end
    assign lvl_o[g] = stab_q;
  end
endmodule

// File: rtl/scp_frame_shifter.sv
module scp_frame_shifter #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int HOLD_W = 8,
  localparam int FRAME_W = DATA_W + ADDR_W,
  localparam int CNT_W   = $clog2(FRAME_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din_i,
  input  logic              sclk_i,
  input  logic              en_i,
  input  logic [HOLD_W-1:0] hold_cycles_i,
  output logic              en_rise_o,
  output logic              sclk_fall_o,
  output logic              commit_o,
  output logic [DATA_W-1:0] data_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              hold_busy_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic              err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic               sclk_prev_q, en_prev_q;
  logic [FRAME_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [HOLD_W-1:0]  hold_q;
  logic               err_q;

  assign en_rise_o   = en_i & ~en_prev_q;
  assign sclk_fall_o = sclk_prev_q & ~sclk_i;
  assign hold_busy_o = (hold_q != '0);
  assign commit_o    = en_rise_o && (cnt_q == CNT_FULL);
  assign data_o      = shift_q[FRAME_W-1:ADDR_W];
  assign addr_o      = shift_q[ADDR_W-1:0];
  assign bit_cnt_o   = cnt_q;
  assign err_o       = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev_q <= 1'b0;
      en_prev_q   <= 1'b0;
      shift_q     <= '0;
      cnt_q       <= '0;
      hold_q      <= '0;
      err_q       <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_i;
      en_prev_q   <= en_i;
      if (hold_busy_o) hold_q <= hold_q - 1'b1;
      if (en_rise_o) begin
        cnt_q  <= '0;
        hold_q <= hold_cycles_i;
      end else if (sclk_fall_o) begin
        if (hold_busy_o) begin
          err_q <= 1'b1;
        end else begin
          shift_q <= {shift_q[FRAME_W-2:0], din_i};
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scp_reg_bank.sv
module scp_reg_bank #(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 3,
  parameter int NUM_REGS   = 7,
  parameter int NUM_STAGED = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          data_i,
  input  logic                       promote_i,
  output logic [NUM_REGS*DATA_W-1:0] cfg_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    logic              hit;
    logic [DATA_W-1:0] act_q;
    assign hit = wr_i && (addr_i == ADDR_W'(g));
    assign cfg_o[g*DATA_W +: DATA_W] = act_q;

    if (g < NUM_STAGED) begin : g_staged
      logic [DATA_W-1:0] stage_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q <= '0;
          act_q   <= '0;
        end else begin
          if (promote_i) act_q <= stage_q;
          if (hit) stage_q <= data_i;
        end
      end
    end else begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) act_q <= '0;
        else if (hit) act_q <= data_i;
      end
    end
  end
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 3,
  parameter int NUM_REGS   = 7,
  parameter int NUM_STAGED = 4,
  parameter int HOLD_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sdata_i,
  input  logic                       sclk_i,
  input  logic                       sen_i,
  input  logic [HOLD_W-1:0]          hold_cycles_i,
  output logic [NUM_REGS*DATA_W-1:0] cfg_o,
  output logic                       hold_err_o
);
  import scp_pkg::*;
  localparam int FRAME_W = DATA_W + ADDR_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  logic [NUM_PINS-1:0] pins, lvl;
  logic                en_rise, sclk_fall, commit, hold_busy;
  logic [DATA_W-1:0]   frm_data;
  logic [ADDR_W-1:0]   frm_addr;
  logic [CNT_W-1:0]    bit_cnt;

  assign pins[PIN_DATA] = sdata_i;
  assign pins[PIN_SCLK] = sclk_i;
  assign pins[PIN_EN]   = sen_i;

  scp_pin_sync #(.N(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pins), .lvl_o(lvl)
  );

  scp_frame_shifter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .HOLD_W(HOLD_W)) u_shift (
    .clk(clk), .rst(rst),
    .din_i(lvl[PIN_DATA]), .sclk_i(lvl[PIN_SCLK]), .en_i(lvl[PIN_EN]),
    .hold_cycles_i(hold_cycles_i),
    .en_rise_o(en_rise), .sclk_fall_o(sclk_fall), .commit_o(commit),
    .data_o(frm_data), .addr_o(frm_addr), .hold_busy_o(hold_busy),
    .bit_cnt_o(bit_cnt), .err_o(hold_err_o)
  );

  scp_reg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
                 .NUM_STAGED(NUM_STAGED)) u_bank (
    .clk(clk), .rst(rst), .wr_i(commit), .addr_i(frm_addr), .data_i(frm_data),
    .promote_i(en_rise), .cfg_o(cfg_o)
  );
endmodule

// File: rtl/serial_cfg_port_chk.sv
module serial_cfg_port_chk #(
  parameter int OUT_W  = 112,
  parameter int CNT_W  = 5,
  parameter int HOLD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              en_rise,
  input logic              sclk_fall,
  input logic              hold_busy,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [HOLD_W-1:0] hold_cycles,
  input logic [OUT_W-1:0]  cfg,
  input logic              err
);
  // R5: outputs move only on an enable rising edge
  p_quiet_outputs_r5: assert property (@(posedge clk) disable iff (rst)
    !en_rise |=> $stable(cfg));
  // R6: bit count restarts after every enable edge
  p_count_clear_r6: assert property (@(posedge clk) disable iff (rst)
    en_rise |=> (bit_cnt == '0));
  // R8: guard window opens after an enable edge
  p_window_open_r8: assert property (@(posedge clk) disable iff (rst)
    (en_rise && hold_cycles != '0) |=> hold_busy);
  // R8: flag rises only from a clock edge inside the window
  p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
    (!err && !(sclk_fall && hold_busy)) |=> !err);
  // R9: flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

bind serial_cfg_port serial_cfg_port_chk #(
  .OUT_W(NUM_REGS*DATA_W), .CNT_W(CNT_W), .HOLD_W(HOLD_W)
) u_chk (
  .clk(clk), .rst(rst), .en_rise(en_rise), .sclk_fall(sclk_fall),
  .hold_busy(hold_busy), .bit_cnt(bit_cnt), .hold_cycles(hold_cycles_i),
  .cfg(cfg_o), .err(hold_err_o)
);

// File: tb/sim_serial_cfg_port.sv
`timescale 1ns/1ps
module sim_serial_cfg_port;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sdata = 1'b0, sclk = 1'b0, sen = 1'b0;
  logic [7:0]   hold_cyc = 8'd8;
  logic [111:0] cfg;
  logic         err;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic [15:0] exp_act [7];
  logic [15:0] exp_stg [4];

  always #2.5 clk = ~clk;

  serial_cfg_port u0 (
    .clk(clk), .rst(rst), .sdata_i(sdata), .sclk_i(sclk), .sen_i(sen),
    .hold_cycles_i(hold_cyc), .cfg_o(cfg), .hold_err_o(err)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [111:0] exp_flat();
    logic [111:0] v;
    for (int k = 0; k < 7; k++) v[k*16 +: 16] = exp_act[k];
    return v;
  endfunction

  task automatic chk_cfg(input string req);
    n_checks++;
    if (cfg !== exp_flat()) begin
      n_errors++;
      $display("FAIL %s cfg actual=%h expected=%h", req, cfg, exp_flat());
    end
  endtask

  task automatic chk_err(input string req, input logic want);
    n_checks++;
    if (err !== want) begin
      n_errors++;
      $display("FAIL %s hold_err actual=%b expected=%b", req, err, want);
    end
  endtask

  // model of one enable rising edge
  task automatic model_edge(input bit ok, input logic [2:0] a, input logic [15:0] d);
    for (int k = 0; k < 4; k++) exp_act[k] = exp_stg[k];
    if (ok && a < 3'd7) begin
      if (a < 3'd4) exp_stg[a] = d;
      else exp_act[a] = d;
    end
  endtask

  // shift nbits of {d,a}, MSB first; bits past 19 are zero
  task automatic shift_bits(input logic [15:0] d, input logic [2:0] a, input int nbits);
    logic [18:0] f;
    f = {d, a};
    sen = 1'b0;
    cyc(16);
    for (int i = 0; i < nbits; i++) begin
      sdata = (i < 19) ? f[18-i] : 1'b0;
      sclk = 1'b1;
      cyc(3);
      sclk = 1'b0;
      cyc(3);
    end
  endtask

  task automatic frame(input logic [15:0] d, input logic [2:0] a, input int nbits);
    shift_bits(d, a, nbits);
    sen = 1'b1;
    cyc(6);
    model_edge(nbits == 19, a, d);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sen = 1'b0; sclk = 1'b0; sdata = 1'b0;
    cyc(3);
    rst = 1'b0;
    for (int k = 0; k < 7; k++) exp_act[k] = '0;
    for (int k = 0; k < 4; k++) exp_stg[k] = '0;
    cyc(2);
  endtask

  task automatic t_reset();
    do_reset();
    chk_cfg("R1");
    chk_err("R1", 1'b0);
  endtask

  task automatic t_direct();
    // R3: latency of exactly three clock edges
    shift_bits(16'hA5C3, 3'd5, 19);
    sen = 1'b1;
    cyc(2);
    chk_cfg("R3 before");
    cyc(1);
    model_edge(1'b1, 3'd5, 16'hA5C3);
    chk_cfg("R3 due");
    cyc(3);
    // R2: bit order seen on both ends of the word
    frame(16'h8001, 3'd4, 19);
    chk_cfg("R2");
    frame(16'h1234, 3'd6, 19);
    chk_cfg("R2 R3");
  endtask

  task automatic t_staged();
    frame(16'hBEEF, 3'd2, 19);
    chk_cfg("R4 held");
    frame(16'h0000, 3'd0, 0);
    chk_cfg("R5 promote");
    frame(16'h1111, 3'd1, 19);
    frame(16'h2222, 3'd1, 19);
    chk_cfg("R5 prior staging");
    frame(16'h0000, 3'd0, 0);
    chk_cfg("R5 extra edge");
    frame(16'h0F0F, 3'd3, 19);
    frame(16'hF0F0, 3'd0, 19);
    chk_cfg("R4 R5 pair");
  endtask

  task automatic t_badcount();
    frame(16'hFFFF, 3'd4, 18);
    chk_cfg("R6 short");
    frame(16'hFFFF, 3'd6, 20);
    chk_cfg("R6 long");
    frame(16'h6C6C, 3'd4, 19);
    chk_cfg("R6 recount");
  endtask

  task automatic t_addr7();
    frame(16'hDEAD, 3'd7, 19);
    chk_cfg("R7");
    frame(16'h0000, 3'd0, 0);
    chk_cfg("R7 staging");
  endtask

  task automatic t_guard();
    chk_err("R8 clean", 1'b0);
    shift_bits(16'h0000, 3'd0, 0);
    sclk = 1'b1;
    cyc(4);
    sen = 1'b1;
    cyc(2);
    sclk = 1'b0;   // lands inside the guard window
    cyc(10);
    model_edge(1'b0, 3'd0, 16'h0);
    chk_err("R8 flagged", 1'b1);
    frame(16'h5A5A, 3'd6, 19);
    chk_cfg("R8 bit ignored");
    frame(16'h0000, 3'd0, 0);
    chk_err("R9", 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    cyc(1);
    t_reset();
    t_direct();
    t_staged();
    t_badcount();
    t_addr7();
    t_guard();
    t_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule